// File: doc/BRIEF.md
# Slope-Controlled Square-Wave Oscillator

This block is a numerically controlled oscillator whose output is a square-like wave. The edges of that wave have a slope that software can hold fixed while the output frequency changes. A 32-bit phase accumulator advances by a tuning word on every clock. The top bits of the phase are folded into a triangle that is centred on the zero crossing. That triangle is then multiplied by a gain and clamped with saturating arithmetic. The gain is meant to be set in inverse proportion to the tuning word. The product of gain and tuning word then stays constant, so the step per clock near the zero crossing and the length of each linear segment do not depend on frequency. The caller computes the reciprocal and supplies the gain.

Two edge shapes are available. Trapezoid mode clamps the scaled triangle directly to full scale. S-curve mode first clamps the scaled triangle to a quarter wave and then passes it through a parabolic sine approximation, which gives rounded corners. At unity gain, S-curve mode is the plain sine-like wave. A gain below unity in that mode is treated as unity, so no separate switch is needed to change over at high frequency. A new tuning word, gain and shape are written together into a holding stage. They go live at the next phase wrap, so a change never cuts a period short. The gain should be chosen so that each linear segment lasts at least twice the settling time of the analog filter that follows.

Top module: `sqnco_top`

## Requirements
- R1: After synchronous reset: sample_o is 0 and wrap_o is 0. The phase is 0, and the live settings are tuning word 0, gain 256 (unity) and trapezoid shape. While the live tuning word is 0, sample_o stays 0.
- R2: Each clock, the phase gains the live tuning word modulo 2^32. wrap_o is high for the one cycle that follows an addition that carried out of bit 31. With tuning word 2^26 there is a wrap every 64 cycles.
- R3: A cycle with cfg_we high captures cfg_tuning, cfg_gain and cfg_shape into a holding stage. The held set becomes live on the clock edge at which the accumulator wraps. If the live tuning word is 0, it becomes live on the next edge instead. Until that edge, the write has no effect on sample_o or on the wrap interval.
- R4: The triangle is taken from u, the top 13 phase bits (0..8191). It is u for u<2048, 4096-u for u<6144, and u-8192 otherwise.
- R5: Trapezoid mode (cfg_shape 0): the sample is floor(tri*gain/256), clamped to the range -2047..2047. The gain is unsigned with 8 fraction bits.
- R6: S-curve mode (cfg_shape 1): v = floor(tri*g/256) clamped to -2048..2048, where g is the gain. The sample is floor(v*(4096-|v|)/2048), clamped to -2047..2047.
- R7: sample_o is registered. It reflects the phase and the live settings as they were one clock earlier.
- R8: sample_o never leaves the range -2047..2047, at any gain.
- R9: In trapezoid mode, the pairs (2^22, 1024), (2^23, 512) and (2^24, 256) all give a step of exactly +32 per clock between in-range samples on a rising edge.
- R10: In S-curve mode, a gain below 256 gives the same output as gain 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the holding stage |
| cfg_tuning | input | 32 | Phase increment per clock |
| cfg_gain | input | 16 | Unsigned slope gain, 8 fraction bits |
| cfg_shape | input | 1 | 0 trapezoid, 1 S-curve |
| sample_o | output | 12 | Signed output sample |
| wrap_o | output | 1 | One-cycle pulse after a phase wrap |

## Verification
The assertions take for granted that reset is held for at least two clocks, so the phase and the live tuning word are known when the history checks begin. They also assume the tuning word may be any value, including 0, and that writes may arrive in any cycle. The stimulus resets before each scenario and holds reset for that long. It writes settings only on falling clock edges, one per write. It uses tuning words that are exact powers of two where the wrap interval or the slope is counted, and odd or near-wrap values elsewhere to exercise folding and saturation.

// File: rtl/sqnco_pkg.sv
package sqnco_pkg;
    localparam int PHASE_W   = 32;
    localparam int OUT_W     = 12;
    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 8;
    localparam int IDX_W     = OUT_W + 1;
    localparam int PROD_W    = IDX_W + GAIN_W + 2;
    localparam int QUARTER   = 1 << (OUT_W - 1);
    localparam int FULL_SCALE = QUARTER - 1;

    localparam logic signed [PROD_W-1:0] Q1_S = PROD_W'(QUARTER);
    localparam logic signed [PROD_W-1:0] Q2_S = PROD_W'(2 * QUARTER);
    localparam logic signed [PROD_W-1:0] Q3_S = PROD_W'(3 * QUARTER);
    localparam logic signed [PROD_W-1:0] Q4_S = PROD_W'(4 * QUARTER);
    localparam logic signed [PROD_W-1:0] FS_S = PROD_W'(FULL_SCALE);
    localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << GAIN_FRAC;

    typedef enum logic {SHAPE_TRAP = 1'b0, SHAPE_SCURVE = 1'b1} shape_e;

    typedef struct packed {
        logic [PHASE_W-1:0] tuning;
        logic [GAIN_W-1:0]  gain;
        shape_e             shape;
    } nco_cfg_t;

    // Fold a phase index into a triangle centred on the rising zero crossing.
    function automatic logic signed [PROD_W-1:0] fold_tri(input logic [IDX_W-1:0] u);
        logic signed [PROD_W-1:0] s;
        s = signed'({{(PROD_W-IDX_W){1'b0}}, u});
        if (s < Q1_S)      return s;
        else if (s < Q3_S) return Q2_S - s;
        else               return s - Q4_S;
    endfunction

    function automatic logic signed [PROD_W-1:0] sat_sym(input logic signed [PROD_W-1:0] x,
                                                         input logic signed [PROD_W-1:0] lim);
        if (x > lim)  return lim;
        if (x < -lim) return -lim;
        return x;
    endfunction

    // The S-curve never runs below unity gain, so it degrades to the plain curve.
    function automatic logic [GAIN_W-1:0] eff_gain(input logic [GAIN_W-1:0] g, input shape_e sh);
        if (sh == SHAPE_SCURVE && g < GAIN_ONE) return GAIN_ONE;
        return g;
    endfunction
endpackage

// File: rtl/sqnco_cfg.sv
module sqnco_cfg
    import sqnco_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  nco_cfg_t wr_cfg,
    input  logic     carry,
    output nco_cfg_t act
);
    nco_cfg_t held;
    logic     held_v;
    logic     load;

    assign load = held_v && (carry || (act.tuning == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= '{tuning: '0, gain: GAIN_ONE, shape: SHAPE_TRAP};
            held   <= '{tuning: '0, gain: GAIN_ONE, shape: SHAPE_TRAP};
            held_v <= 1'b0;
        end else begin
            if (load) begin
                act    <= held;
                held_v <= 1'b0;
            end
            if (we) begin
                held   <= wr_cfg;
                held_v <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sqnco_phase.sv
module sqnco_phase
    import sqnco_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] tuning,
    output logic [PHASE_W-1:0] phase_q,
    output logic               carry,
    output logic               wrap_q
);
    logic [PHASE_W-1:0] phase_d;

    assign {carry, phase_d} = {1'b0, phase_q} + {1'b0, tuning};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            wrap_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            wrap_q  <= carry;
        end
    end
endmodule

// File: rtl/sqnco_shaper.sv
module sqnco_shaper
    import sqnco_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [IDX_W-1:0]         idx,
    input  logic [GAIN_W-1:0]        gain,
    input  shape_e                   shape,
    output logic signed [OUT_W-1:0]  sample
);
    logic signed [PROD_W-1:0] tri_v, gain_v, prod, scaled;
    logic signed [PROD_W-1:0] trap_v, v, mag, span, sq, curve_v, res;

    always_comb begin
        tri_v  = fold_tri(idx);
        gain_v = signed'({{(PROD_W-GAIN_W){1'b0}}, eff_gain(gain, shape)});
        prod   = tri_v * gain_v;
        scaled = prod >>> GAIN_FRAC;
        // trapezoid: clamp the scaled ramp straight to full scale
        trap_v = sat_sym(scaled, FS_S);
        // S-curve: limit to a quarter wave, then a parabolic sine approximation
        v       = sat_sym(scaled, Q1_S);
        mag     = (v < 0) ? -v : v;
        span    = Q2_S - mag;
        sq      = v * span;
        curve_v = sat_sym(sq >>> (OUT_W - 1), FS_S);
        res     = (shape == SHAPE_SCURVE) ? curve_v : trap_v;
    end

    always_ff @(posedge clk) begin
        if (rst) sample <= '0;
        else     sample <= OUT_W'(res);
    end
endmodule

// File: rtl/sqnco_top.sv
module sqnco_top
    import sqnco_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [PHASE_W-1:0]      cfg_tuning,
    input  logic [GAIN_W-1:0]       cfg_gain,
    input  logic                    cfg_shape,
    output logic signed [OUT_W-1:0] sample_o,
    output logic                    wrap_o
);
    nco_cfg_t           wr_cfg, act_cfg;
    logic [PHASE_W-1:0] act_tuning, phase_q;
    logic               carry;

    assign wr_cfg     = '{tuning: cfg_tuning, gain: cfg_gain, shape: shape_e'(cfg_shape)};
    assign act_tuning = act_cfg.tuning;

    sqnco_cfg cfg_i (
        .clk(clk), .rst(rst), .we(cfg_we), .wr_cfg(wr_cfg),
        .carry(carry), .act(act_cfg)
    );

    sqnco_phase phase_i (
        .clk(clk), .rst(rst), .tuning(act_tuning),
        .phase_q(phase_q), .carry(carry), .wrap_q(wrap_o)
    );

    sqnco_shaper shaper_i (
        .clk(clk), .rst(rst), .idx(phase_q[PHASE_W-1 -: IDX_W]),
        .gain(act_cfg.gain), .shape(act_cfg.shape), .sample(sample_o)
    );
endmodule

// File: rtl/sqnco_chk.sv
module sqnco_chk
    import sqnco_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic signed [OUT_W-1:0] sample,
    input logic                    wrap,
    input logic [PHASE_W-1:0]      tuning_act,
    input logic [PHASE_W-1:0]      phase
);
    localparam logic signed [OUT_W-1:0] FS_O = OUT_W'(FULL_SCALE);

    // R8: output stays within symmetric full scale
    a_r8_within_full_scale: assert property (@(posedge clk) disable iff (rst)
        (sample <= FS_O) && (sample >= -FS_O));

    // R3: live tuning changes only at a wrap or from the stopped state
    a_r3_load_at_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(tuning_act) |-> (wrap || ($past(tuning_act) == '0)));

    // R2: a wrap pulse follows a drop in phase
    a_r2_wrap_phase_drop: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (phase < $past(phase)));

    // R2: without a wrap the phase does not decrease
    a_r2_no_wrap_monotonic: assert property (@(posedge clk) disable iff (rst)
        !wrap |-> (phase >= $past(phase)));

    // R1: a stopped accumulator never wraps
    a_r1_no_wrap_when_stopped: assert property (@(posedge clk) disable iff (rst)
        ($past(tuning_act) == '0) |-> !wrap);
endmodule

bind sqnco_top sqnco_chk chk_i (
    .clk(clk), .rst(rst), .sample(sample_o), .wrap(wrap_o),
    .tuning_act(act_tuning), .phase(phase_q)
);

// File: tb/sqnco_tb.sv
module sqnco_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [31:0] cfg_tuning = '0;
    logic [15:0] cfg_gain = 16'd256;
    logic cfg_shape = 1'b0;
    logic signed [11:0] sample_o;
    logic wrap_o;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #4 clk = ~clk;

    sqnco_top dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tuning(cfg_tuning),
        .cfg_gain(cfg_gain), .cfg_shape(cfg_shape), .sample_o(sample_o), .wrap_o(wrap_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint clampv(input longint x, input longint lim);
        if (x > lim) return lim;
        if (x < -lim) return -lim;
        return x;
    endfunction

    // Expected sample from R4, R5, R6, R10
    function automatic longint exp_sample(input logic [31:0] ph, input logic [15:0] g, input logic sh);
        longint u, t, ge, sc, v, m;
        u = longint'(ph >> 19);
        if (u < 2048) t = u;
        else if (u < 6144) t = 4096 - u;
        else t = u - 8192;
        ge = longint'(g);
        if (sh && ge < 256) ge = 256;
        sc = (t * ge) >>> 8;
        if (!sh) return clampv(sc, 2047);
        v = clampv(sc, 2048);
        m = (v < 0) ? -v : v;
        return clampv((v * (4096 - m)) >>> 11, 2047);
    endfunction

    // Reference model and scoreboard queue
    typedef struct { longint s; bit w; } exp_t;
    exp_t exp_q[$];
    logic [31:0] m_phase, m_tw, m_ptw;
    logic [15:0] m_gain, m_pg;
    logic m_shape, m_ps, m_pv;

    always @(posedge clk) begin
        logic [32:0] sum;
        bit ld;
        exp_t e;
        if (rst) begin
            m_phase = '0; m_tw = '0; m_gain = 16'd256; m_shape = 1'b0; m_pv = 1'b0;
            exp_q.delete();
        end else begin
            sum = {1'b0, m_phase} + {1'b0, m_tw};
            e.s = exp_sample(m_phase, m_gain, m_shape);   // R7: output lags one clock
            e.w = sum[32];
            exp_q.push_back(e);
            ld = m_pv && (sum[32] || m_tw == 0);
            if (ld) begin
                m_tw = m_ptw; m_gain = m_pg; m_shape = m_ps; m_pv = 1'b0;
            end
            if (cfg_we) begin
                m_ptw = cfg_tuning; m_pg = cfg_gain; m_ps = cfg_shape; m_pv = 1'b1;
            end
            m_phase = sum[31:0];
        end
    end

    // Monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (!rst && exp_q.size() > 0 && !done) begin
            e = exp_q.pop_front();
            check({cur_req, " sample"}, longint'(sample_o), e.s);
            check({cur_req, " wrap"}, longint'(wrap_o), longint'(e.w));
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_cfg(input logic [31:0] tw, input logic [15:0] g, input logic sh);
        @(negedge clk);
        cfg_we = 1'b1; cfg_tuning = tw; cfg_gain = g; cfg_shape = sh;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic measure(output int n);
        do @(negedge clk); while (!wrap_o);
        n = 0;
        do begin @(negedge clk); n++; end while (!wrap_o);
    endtask

    task automatic slope_run(input logic [31:0] tw, input logic [15:0] g);
        int prev, cur, seen;
        cur_req = "R5";
        do_reset();
        write_cfg(tw, g, 1'b0);
        repeat (4) @(negedge clk);
        prev = int'(sample_o);
        seen = 0;
        for (int i = 0; i < int'(32'hFFFF_FFFF / tw) + 16; i++) begin
            @(negedge clk);
            cur = int'(sample_o);
            if (cur > prev && cur < 2047 && prev > -2047) begin
                check("R9 slope step", cur - prev, 32);
                seen++;
            end
            prev = cur;
        end
        tests++;
        if (seen < 10) begin
            fails++;
            $display("FAIL R9 rising steps actual=%0d expected>=10", seen);
        end
    endtask

    task automatic bound_run(input logic [31:0] tw, input logic sh);
        int s;
        cur_req = "R8";
        do_reset();
        write_cfg(tw, 16'hFFFF, sh);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            s = int'(sample_o);
            tests++;
            if (s > 2047 || s < -2047) begin
                fails++;
                $display("FAIL R8 actual=%0d expected within +-2047", s);
            end
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values, then a stopped accumulator holds zero
        check("R1 sample after reset", longint'(sample_o), 0);
        check("R1 wrap after reset", longint'(wrap_o), 0);
        repeat (10) @(negedge clk);
        check("R1 sample while stopped", longint'(sample_o), 0);

        // R2 / R7: wrap interval at 2^26
        cur_req = "R7";
        do_reset();
        write_cfg(32'h0400_0000, 16'd256, 1'b0);
        for (int k = 0; k < 3; k++) begin
            measure(n);
            check("R2 wrap interval", n, 64);
        end

        // R3: write mid-period; current period unaffected, next uses new word
        cur_req = "R3";
        n = 0;
        write_cfg(32'h0200_0000, 16'd600, 1'b0);
        n = 2;
        while (!wrap_o) begin @(negedge clk); n++; end
        check("R3 period after write", n, 64);
        measure(n);
        check("R3 new period", n, 128);

        // R9 slope pairs (model covers R5)
        slope_run(32'h0040_0000, 16'd1024);
        slope_run(32'h0080_0000, 16'd512);
        slope_run(32'h0100_0000, 16'd256);

        // R8 saturation at maximum gain, both shapes
        bound_run(32'h0012_3457, 1'b0);
        bound_run(32'h0012_3457, 1'b1);

        // R6: S-curve with an odd tuning word
        cur_req = "R6";
        do_reset();
        write_cfg(32'h0020_3039, 16'd3000, 1'b1);
        repeat (3000) @(negedge clk);

        // R10: S-curve below unity gain matches unity gain
        cur_req = "R10";
        do_reset();
        write_cfg(32'h0812_3457, 16'd100, 1'b1);
        repeat (400) @(negedge clk);

        // R4: high tuning word exercises every fold region
        cur_req = "R4";
        do_reset();
        write_cfg(32'hF123_4567, 16'd256, 1'b0);
        repeat (400) @(negedge clk);
        write_cfg(32'h3456_789B, 16'd700, 1'b0);
        repeat (400) @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 190000);
        done = 1'b1;
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule